// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This unit carries out one block load or block store of any subset of sixteen registers. A single-cycle start pulse supplies a 16-bit register selection mask, a 32-bit base address, and four mode bits: direction (up or down), step timing (before or after), base update enable, and load-versus-store. The unit then issues one memory request per word. Each request carries a word address and the index of the register being moved, and stays posted until the memory side accepts it with a ready handshake. The memory and the register file sit outside this block.

The registers always move in ascending index order, and the lowest selected register always lands at the lowest address. For a downward transfer, the unit first computes the bottom of the block (base minus four times the register count) and then climbs from there. After the final accepted request, the unit presents the updated base value together with a base-update enable, and flags the case where the highest-numbered register (the program counter) was loaded, because that load changes control flow. Common stack idioms reduce to these modes. A full-descending push is a down/before store and its pop is an up/after load. An empty-ascending push is an up/after store.

The controller has three states. `ST_IDLE` waits for start. `ST_XFER` posts requests. `ST_DONE` lasts one cycle and reports the result. The transitions are:
- IDLE→XFER on start with a non-empty mask.
- IDLE→DONE on start with an empty mask.
- XFER→XFER when a request is accepted and registers remain.
- XFER→DONE when the last request is accepted.
- DONE→IDLE unconditionally.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `req_o` and `done_o` are all 0.
- R2: Every register whose mask bit is set is transferred exactly once, in ascending index order, and no unselected register is transferred.
- R3: In up/after mode (`up_i`=1, `pre_i`=0), the first address is the base and each later address is 4 higher. Example: base 0x1000 with three registers gives 0x1000, 0x1004 and 0x1008.
- R4: In up/before mode (`up_i`=1, `pre_i`=1), the first address is base+4, then it rises by 4.
- R5: In down/after mode (`up_i`=0, `pre_i`=0), the first address is base−4·N+4, then it rises by 4, where N is the number of set mask bits.
- R6: In down/before mode (`up_i`=0, `pre_i`=1), the first address is base−4·N, then it rises by 4.
- R7: During the done cycle, `wb_base_o` equals base+4·N for up modes and base−4·N for down modes (modulo 2^32), and `wb_en_o` equals the writeback bit given at start.
- R8: While `req_o` is 1 and `ready_i` is 0, the posted address and register index hold unchanged into the next cycle.
- R9: A start with an all-zero mask produces `done_o` in the next cycle and no request.
- R10: `pc_load_o` is 1 in the done cycle exactly when the operation was a load (`load_i`=1) and mask bit 15 was set, and it is 0 at all other times.
- R11: A start pulse, and any change of the operation inputs, while the unit is busy has no effect on the operation in progress.
- R12: `req_load_o` equals the load bit captured at start on every request of that operation.
- R13: `done_o` is a single-cycle pulse. For a non-empty mask, the first request is posted in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| mask_i | input | 16 | Register selection mask, bit i selects register i |
| base_i | input | 32 | Base address |
| up_i | input | 1 | 1 = addresses above the base, 0 = below |
| pre_i | input | 1 | 1 = step before the first access, 0 = after |
| wb_i | input | 1 | Request a base update |
| load_i | input | 1 | 1 = load, 0 = store |
| ready_i | input | 1 | Memory accepts the posted request |
| req_o | output | 1 | Request posted |
| req_addr_o | output | 32 | Word address of the posted request |
| req_idx_o | output | 4 | Register index of the posted request |
| req_load_o | output | 1 | Direction of the posted request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete, one cycle |
| wb_en_o | output | 1 | Base update enable, valid with `done_o` |
| wb_base_o | output | 32 | Updated base value, valid with `done_o` |
| pc_load_o | output | 1 | Register 15 was loaded, valid with `done_o` |

## Verification
A start accepted at clock edge k puts either the first request or, for an empty mask, `done_o` on the ports after edge k, so the bench samples at the falling edge that follows. A request accepted at edge j is replaced by the next address and index after edge j, or by `done_o` if it was the last. The bench drives `ready_i` and samples the outputs only on falling edges. After each sample it advances its own expected index and address only when it had asserted ready in the previous cycle. The result fields are compared in the single cycle in which `done_o` is seen, and the cycle after that is checked for an idle, request-free state.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE
    } xfer_state_e;

    function automatic logic [4:0] count_ones16(input logic [15:0] v);
        logic [4:0] acc;
        acc = '0;
        for (int i = 0; i < 16; i++) begin
            acc = acc + 5'(v[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec,
    output logic [IDXW-1:0] idx,
    output logic            only
);
    logic [NREG-1:0] rest;

    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDXW'(i);
            end
        end
    end

    assign rest = vec & (vec - NREG'(1));
    assign only = (rest == '0);

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
    parameter int AW   = 32,
    parameter int CNTW = 5,
    parameter int WSH  = 2
) (
    input  logic [AW-1:0]   base,
    input  logic [CNTW-1:0] cnt,
    input  logic            up,
    input  logic            pre,
    output logic [AW-1:0]   first_addr,
    output logic [AW-1:0]   end_base
);
    localparam logic [AW-1:0] STEP = AW'(1) << WSH;

    logic [AW-1:0] span;
    logic [AW-1:0] floor_addr;

    assign span       = AW'(cnt) << WSH;
    assign floor_addr = base - span;

    always_comb begin
        if (up) begin
            first_addr = pre ? base + STEP : base;
            end_base   = base + span;
        end else begin
            first_addr = pre ? floor_addr : floor_addr + STEP;
            end_base   = floor_addr;
        end
    end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WSH  = 2,
    localparam int IDXW = $clog2(NREG),
    localparam int CNTW = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic            up_i,
    input  logic            pre_i,
    input  logic            wb_i,
    input  logic            load_i,
    input  logic            ready_i,
    output logic            req_o,
    output logic [AW-1:0]   req_addr_o,
    output logic [IDXW-1:0] req_idx_o,
    output logic            req_load_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            wb_en_o,
    output logic [AW-1:0]   wb_base_o,
    output logic            pc_load_o
);
    localparam logic [AW-1:0] STEP = AW'(1) << WSH;

    xfer_state_e state_q, state_d;

    logic [NREG-1:0] left_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   endb_q;
    logic            wb_q;
    logic            load_q;
    logic            pc_q;

    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   end_base;
    logic [IDXW-1:0] cur_idx;
    logic            last_one;
    logic            accept;
    logic            launch;

    assign cnt = CNTW'(count_ones16(16'(mask_i)));

    blkxfer_addr #(.AW(AW), .CNTW(CNTW), .WSH(WSH)) u_addr (
        .base       (base_i),
        .cnt        (cnt),
        .up         (up_i),
        .pre        (pre_i),
        .first_addr (first_addr),
        .end_base   (end_base)
    );

    blkxfer_pick #(.NREG(NREG)) u_pick (
        .vec  (left_q),
        .idx  (cur_idx),
        .only (last_one)
    );

    assign launch = (state_q == ST_IDLE) && start_i;
    assign accept = (state_q == ST_XFER) && ready_i;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (mask_i == '0) ? ST_DONE : ST_XFER;
            ST_XFER: if (ready_i && last_one) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            addr_q <= '0;
            endb_q <= '0;
            wb_q   <= 1'b0;
            load_q <= 1'b0;
            pc_q   <= 1'b0;
        end else if (launch) begin
            left_q <= mask_i;
            addr_q <= first_addr;
            endb_q <= end_base;
            wb_q   <= wb_i;
            load_q <= load_i;
            pc_q   <= load_i & mask_i[NREG-1];
        end else if (accept) begin
            left_q <= left_q & (left_q - NREG'(1));
            addr_q <= addr_q + STEP;
        end
    end

    // outputs decoded from state
    always_comb begin
        req_o      = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        wb_en_o    = 1'b0;
        pc_load_o  = 1'b0;
        req_addr_o = addr_q;
        req_idx_o  = cur_idx;
        req_load_o = load_q;
        wb_base_o  = endb_q;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_XFER: req_o  = 1'b1;
            ST_DONE: begin
                done_o    = 1'b1;
                wb_en_o   = wb_q;
                pc_load_o = pc_q;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
    parameter int AW   = 32,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready_i,
    input logic            req_o,
    input logic [AW-1:0]   req_addr_o,
    input logic [IDXW-1:0] req_idx_o,
    input logic            req_load_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            pc_load_o
);
    a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ready_i) |=> (req_o && $stable(req_addr_o) && $stable(req_idx_o)));

    a_r2_index_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ready_i) |=> (!req_o || (req_idx_o > $past(req_idx_o))));

    a_r3_address_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ready_i) |=> (!req_o || (req_addr_o == $past(req_addr_o) + AW'(4))));

    a_r12_direction_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o)) |-> $stable(req_load_o));

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r13_req_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && done_o));

    a_r10_pc_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> done_o);

    a_r1_busy_covers_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o || done_o) |-> busy_o);

endmodule

bind blkxfer_seq blkxfer_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .req_o      (req_o),
    .req_addr_o (req_addr_o),
    .req_idx_o  (req_idx_o),
    .req_load_o (req_load_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pc_load_o  (pc_load_o)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        req_o, req_load_o, busy_o, done_o, wb_en_o, pc_load_o;
    logic [31:0] req_addr_o, wb_base_o;
    logic [3:0]  req_idx_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    blkxfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .base_i(base_i),
        .up_i(up_i), .pre_i(pre_i), .wb_i(wb_i), .load_i(load_i), .ready_i(ready_i),
        .req_o(req_o), .req_addr_o(req_addr_o), .req_idx_o(req_idx_o),
        .req_load_o(req_load_o), .busy_o(busy_o), .done_o(done_o),
        .wb_en_o(wb_en_o), .wb_base_o(wb_base_o), .pc_load_o(pc_load_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic int next_bit(input logic [15:0] m, input int from);
        for (int i = from; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input bit up, input bit pre);
        logic [31:0] span = 32'(n) * 32'd4;
        if (up) return pre ? b + 32'd4 : b;
        return pre ? b - span : b - span + 32'd4;
    endfunction

    function automatic logic [31:0] exp_end(input logic [31:0] b, input int n, input bit up);
        logic [31:0] span = 32'(n) * 32'd4;
        return up ? b + span : b - span;
    endfunction

    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input bit up, input bit pre,
                          input bit wb, input bit ld, input bit poke, input int rdy_pct);
        int n = ones(m);
        logic [31:0] ea = exp_first(b, n, up, pre);
        int nxt = next_bit(m, 0);
        int seen = 0;
        int cyc = 0;
        bit fin = 1'b0;
        string mtag;
        if (up && !pre) mtag = "R3";
        else if (up) mtag = "R4";
        else if (!pre) mtag = "R5";
        else mtag = "R6";

        @(negedge clk);
        start_i = 1'b1; mask_i = m; base_i = b; up_i = up; pre_i = pre; wb_i = wb; load_i = ld;
        ready_i = 1'b0;
        @(negedge clk);
        if (n > 0) chk(req_o == 1'b1 && done_o == 1'b0, "R13 first request", 32'(req_o), 32'd1);
        else chk(done_o == 1'b1 && req_o == 1'b0, "R9 empty mask done", 32'(done_o), 32'd1);
        // R11: keep poking start with other operands while busy
        start_i = poke;
        if (poke) begin
            mask_i = ~m; base_i = ~b; up_i = ~up; pre_i = ~pre; wb_i = ~wb; load_i = ~ld;
        end
        while (!fin) begin
            if (req_o) begin
                chk(int'(req_idx_o) == nxt, "R2 register index", 32'(req_idx_o), 32'(nxt));
                chk(req_addr_o == ea, {mtag, " request address"}, req_addr_o, ea);
                chk(req_load_o == ld, "R12 request direction", 32'(req_load_o), 32'(ld));
                ready_i = (($urandom % 100) < rdy_pct);
                if (ready_i) begin
                    seen++;
                    ea = ea + 32'd4;
                    nxt = next_bit(m, nxt + 1);
                end
            end else begin
                ready_i = 1'b0;
                if (done_o) begin
                    chk(seen == n, "R2 transfer count", 32'(seen), 32'(n));
                    chk(wb_base_o == exp_end(b, n, up), "R7 end base", wb_base_o, exp_end(b, n, up));
                    chk(wb_en_o == wb, "R7 writeback enable", 32'(wb_en_o), 32'(wb));
                    chk(pc_load_o == (ld & m[15]), "R10 pc load flag", 32'(pc_load_o), 32'(ld & m[15]));
                    start_i = 1'b0;
                    fin = 1'b1;
                end else begin
                    chk(1'b0, "R13 neither request nor done while busy", 32'(busy_o), 32'd1);
                    fin = 1'b1;
                end
            end
            cyc++;
            if (cyc > 400) begin
                chk(1'b0, "R2 operation watchdog", 32'(cyc), 32'd400);
                fin = 1'b1;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b0;
        chk(!busy_o && !req_o && !done_o, "R11 R13 idle after done", 32'({busy_o, req_o, done_o}), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !req_o && !done_o, "R1 reset state", 32'({busy_o, req_o, done_o}), 32'd0);

        run_op(16'h0023, 32'h0000_1000, 1, 0, 1, 0, 0, 100);   // R3 worked example
        run_op(16'h0023, 32'h0000_1000, 1, 1, 1, 1, 0, 50);    // R4
        run_op(16'h8421, 32'h0000_2000, 0, 0, 1, 1, 1, 40);    // R5, R10, R11
        run_op(16'hC00F, 32'h0000_3000, 0, 1, 1, 0, 0, 60);    // R6 push, store with bit 15
        run_op(16'h0000, 32'h0000_4000, 1, 0, 1, 1, 1, 100);   // R9
        run_op(16'hFFFF, 32'h0000_0008, 0, 1, 1, 1, 0, 30);    // all registers, wraparound
        run_op(16'h8000, 32'hFFFF_FFFC, 1, 0, 0, 1, 0, 100);   // only PC, R10
        run_op(16'h0001, 32'h0000_0100, 0, 0, 0, 0, 1, 20);    // R8 long stalls

        for (int k = 0; k < 60; k++) begin
            run_op(16'($urandom), {$urandom} & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 20 + int'($urandom % 81));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R13 global watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule